// File: doc/BRIEF.md
# Two-Digit BCD Countdown Alarm Timer

This block is a small countdown timer driven by a ten-line keypad. Exactly one key line is raised at a time. While the timer sits idle, the pressed key is turned into a decimal digit, and that digit is written into both the tens and the units BCD registers, so key 6 shows as "66".

A start pulse launches a countdown from the loaded value. The count falls by one BCD step on every clock cycle. When the units digit is at 0, it borrows from the tens digit. Holding stop freezes the count, and releasing stop lets the count carry on. When the count lands on 00, the alarm output rises and stays high. The timer then returns to idle, where a new key can be loaded.

The alarm is cleared by holding stop while the count shows 00, or by reset. Reset is synchronous and active low. It clears both digits and the alarm, and it returns the timer to idle. Scaling the clock down to seconds and driving a display are left to the logic around this block.

Top module: `bcd_alarm_timer`

## Requirements
- R1: With the timer idle and key line j (bit j of `keys`, j = 0..9) the only line high, both `tens` and `units` equal j after the next clock edge.
- R2: A key bus with no line high, or with more than one line high, loads nothing, and both digits keep their values.
- R3: While `rst_n` is low at a clock edge, the digits become 00 and `alarm` becomes 0 at that edge, and the timer returns to idle.
- R4: If `start` is high at an idle edge and the count is not 00, the count keeps its value at that edge. It then falls by one on each later edge: units minus one, or units to 9 and tens minus one when units is 0.
- R5: While the countdown runs, key lines and `start` have no effect on the count.
- R6: While `stop` is high during a countdown, both digits hold. After `stop` falls, the countdown resumes from the held value on the next edge.
- R7: At the edge where the count becomes 00, `alarm` rises. It stays high while no clearing condition occurs. The timer is idle afterwards, so a key loads again.
- R8: `stop` high at an idle edge while the count is 00 clears `alarm`.
- R9: `start` high at an idle edge while the count is 00 raises `alarm` at that edge, and the digits stay 00.
- R10: When `start` and a valid key are both high at an idle edge, `start` wins and the key is not loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| keys | input | 10 | One-hot key lines; bit j stands for digit j |
| start | input | 1 | Begins the countdown when sampled high in idle |
| stop | input | 1 | Freezes the countdown; at 00 in idle it clears the alarm |
| tens | output | 4 | BCD tens digit |
| units | output | 4 | BCD units digit |
| alarm | output | 1 | High once the count has reached 00 |

## Verification
Every result is held in a register, so each result is due at the first rising edge that samples its cause. A key load, an alarm set or an alarm clear is visible one edge after the input. After a start, the count keeps its value at that first edge, and the first decrement appears at the second edge. The bench changes inputs on the falling edge and reads outputs on a later falling edge, stepping a model of the count by one BCD decrement per elapsed edge. This way each comparison falls half a period after the edge that should have produced the value.

// File: rtl/timer_pkg.sv
// Package: shared types for the BCD countdown timer.
// Assumes: no more than two controller states are needed.
package timer_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_t;
endpackage

// File: rtl/tmr_key_decode.sv
// Module: tmr_key_decode
// Turns the one-hot key bus into a digit code, and flags whether exactly one line is up.
// Assumes: the key lines are already synchronous to clk; digit is meaningful only when valid is high.
module tmr_key_decode #(
    parameter int N_KEYS = 10,
    parameter int DW     = 4
) (
    input  logic [N_KEYS-1:0] keys,
    output logic              valid,
    output logic [DW-1:0]     digit
);
    // Purpose: exactly-one-hot detection and index encoding.
    always_comb begin
        valid = $onehot(keys);
        digit = '0;
        for (int i = 0; i < N_KEYS; i++) begin
            if (keys[i]) digit = digit | DW'(i);
        end
    end

    // R1: a valid code must name the single raised line.
    always_comb begin
        if (valid) begin
            a_r1_digit_matches_line: assert (keys == (N_KEYS'(1) << digit))
                else $error("key decode mismatch");
        end
    end
endmodule

// File: rtl/tmr_bcd_count.sv
// Module: tmr_bcd_count
// Two-digit BCD register with a broadcast load (same digit into both places) and a single-step decrement.
// Assumes: load and dec are never high together, and dec is never issued at 00 (the controller guarantees both).
module tmr_bcd_count #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_digit,
    input  logic          dec,
    output logic [DW-1:0] tens,
    output logic [DW-1:0] units,
    output logic          at_zero,
    output logic          at_one
);
    localparam logic [DW-1:0] MAX_DIGIT = DW'(9);

    // Purpose: digit registers with reset, load and BCD borrow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tens  <= '0;
            units <= '0;
        end else if (load) begin
            tens  <= load_digit;
            units <= load_digit;
        end else if (dec) begin
            if (units == '0) begin
                units <= MAX_DIGIT;
                tens  <= tens - DW'(1);
            end else begin
                units <= units - DW'(1);
            end
        end
    end

    // Purpose: terminal-count flags for the controller.
    always_comb begin
        at_zero = (tens == '0) && (units == '0);
        at_one  = (tens == '0) && (units == DW'(1));
    end

    // R4: the digits never leave the BCD range.
    a_r4_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tens <= MAX_DIGIT) && (units <= MAX_DIGIT))
        else $error("digit out of BCD range");

    // R4: a decrement request never reaches a count of 00.
    a_r4_no_dec_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !at_zero)
        else $error("decrement below zero");
endmodule

// File: rtl/tmr_ctrl.sv
// Module: tmr_ctrl
// Idle/run sequencer: issues loads in idle, decrements while running, and owns the alarm flag.
// Assumes: start and stop are sampled as levels; a held start has no further effect while running.
module tmr_ctrl
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic key_ok,
    input  logic at_zero,
    input  logic at_one,
    output logic load,
    output logic dec,
    output logic alarm,
    output logic running
);
    tmr_state_t state;

    // Purpose: command decode from the present state.
    always_comb begin
        running = (state == ST_RUN);
        load    = !running && !start && key_ok;
        dec     = running && !stop;
    end

    // Purpose: state and alarm register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            alarm <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (stop && at_zero) begin
                        alarm <= 1'b0;
                    end else if (start && at_zero) begin
                        alarm <= 1'b1;
                    end else if (start) begin
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (!stop && at_one) begin
                        alarm <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: the run state never sits on a count of 00.
    a_r5_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !at_zero)
        else $error("running at zero");

    // R8: stop seen at 00 in idle leaves the alarm low.
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && stop && at_zero) |=> !alarm)
        else $error("alarm not cleared");
endmodule

// File: rtl/bcd_alarm_timer.sv
// Module: bcd_alarm_timer (top)
// Keypad-loaded two-digit BCD countdown with a pause and a sticky alarm.
// Assumes: all inputs are synchronous to clk; one count step per clock cycle.
module bcd_alarm_timer #(
    parameter int N_KEYS = 10,
    parameter int DW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_KEYS-1:0] keys,
    input  logic              start,
    input  logic              stop,
    output logic [DW-1:0]     tens,
    output logic [DW-1:0]     units,
    output logic              alarm
);
    logic          key_ok;
    logic [DW-1:0] key_digit;
    logic          load, dec, running, at_zero, at_one;

    tmr_key_decode #(.N_KEYS(N_KEYS), .DW(DW)) u_dec (
        .keys  (keys),
        .valid (key_ok),
        .digit (key_digit)
    );

    tmr_bcd_count #(.DW(DW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_digit (key_digit),
        .dec        (dec),
        .tens       (tens),
        .units      (units),
        .at_zero    (at_zero),
        .at_one     (at_one)
    );

    tmr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .stop    (stop),
        .key_ok  (key_ok),
        .at_zero (at_zero),
        .at_one  (at_one),
        .load    (load),
        .dec     (dec),
        .alarm   (alarm),
        .running (running)
    );

    // R6: a paused countdown holds both digits.
    a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (running && stop) |=> $stable({tens, units}))
        else $error("count moved during stop");

    // R4: an unpaused countdown moves every cycle.
    a_r4_run_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !stop) |=> ({tens, units} != $past({tens, units})))
        else $error("count did not move");

    // R7: the alarm only rises together with a count of 00.
    a_r7_alarm_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> ((tens == '0) && (units == '0)))
        else $error("alarm rose away from zero");
endmodule

// File: tb/bcd_alarm_timer_tb_top.sv
// Directed bench: inputs change on the falling edge, outputs are read on a later falling edge.
module bcd_alarm_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] keys = '0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic [3:0] tens, units;
    logic       alarm;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    bcd_alarm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .keys(keys), .start(start), .stop(stop),
        .tens(tens), .units(units), .alarm(alarm)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] bcd_dec(input logic [7:0] v);
        if (v[3:0] == 4'd0) return {v[7:4] - 4'd1, 4'd9};
        return {v[7:4], v[3:0] - 4'd1};
    endfunction

    task automatic press(input int j);
        keys = 10'd1 << j;
        step(1);
        keys = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        chk("R3 digits after reset", {tens, units}, 8'h00);
        chk("R3 alarm after reset", {7'd0, alarm}, 8'h00);
    endtask

    task automatic t_decode();
        for (int j = 0; j < 10; j++) begin
            press(j);
            chk("R1 key load", {tens, units}, {j[3:0], j[3:0]});
        end
    endtask

    task automatic t_invalid();
        press(4);
        keys = '0;
        step(2);
        chk("R2 empty bus", {tens, units}, 8'h44);
        keys = 10'b00_0000_0011;
        step(1);
        chk("R2 two lines", {tens, units}, 8'h44);
        keys = 10'b10_0010_0000;
        step(1);
        keys = '0;
        chk("R2 two lines high", {tens, units}, 8'h44);
    endtask

    task automatic t_countdown();
        logic [7:0] m;
        press(2);
        start = 1'b1;
        step(1);
        start = 1'b0;
        chk("R4 start edge holds", {tens, units}, 8'h22);
        m = 8'h22;
        while (m != 8'h01) begin
            step(1);
            m = bcd_dec(m);
            chk("R4 count step", {tens, units}, m);
        end
        chk("R7 no alarm at 01", {7'd0, alarm}, 8'h00);
        step(1);
        chk("R7 reaches 00", {tens, units}, 8'h00);
        chk("R7 alarm rises", {7'd0, alarm}, 8'h01);
        step(5);
        chk("R7 alarm sticky", {7'd0, alarm}, 8'h01);
        chk("R7 stays 00", {tens, units}, 8'h00);
        stop = 1'b1;
        step(1);
        stop = 1'b0;
        chk("R8 stop clears alarm", {7'd0, alarm}, 8'h00);
        press(3);
        chk("R7 idle reload", {tens, units}, 8'h33);
    endtask

    task automatic t_pause();
        logic [7:0] m;
        press(5);
        start = 1'b1;
        step(1);
        start = 1'b0;
        step(3);
        chk("R6 before stop", {tens, units}, 8'h52);
        stop = 1'b1;
        step(4);
        chk("R6 held", {tens, units}, 8'h52);
        stop = 1'b0;
        step(1);
        chk("R6 resume", {tens, units}, 8'h51);
        m = 8'h51;
        keys = 10'd1 << 9;
        start = 1'b1;
        step(2);
        keys = '0;
        start = 1'b0;
        m = bcd_dec(bcd_dec(m));
        chk("R5 key and start ignored", {tens, units}, m);
        while (m != 8'h00) begin
            step(1);
            m = bcd_dec(m);
        end
        chk("R7 alarm after pause", {alarm, 3'd0, tens}, 8'h80);
        stop = 1'b1;
        step(1);
        stop = 1'b0;
        chk("R8 clear", {7'd0, alarm}, 8'h00);
    endtask

    task automatic t_start_zero();
        t_reset();
        start = 1'b1;
        step(1);
        start = 1'b0;
        chk("R9 immediate alarm", {7'd0, alarm}, 8'h01);
        step(3);
        chk("R9 digits stay 00", {tens, units}, 8'h00);
        stop = 1'b1;
        step(1);
        stop = 1'b0;
    endtask

    task automatic t_priority();
        press(4);
        keys = 10'd1 << 7;
        start = 1'b1;
        step(1);
        keys = '0;
        start = 1'b0;
        chk("R10 start beats key", {tens, units}, 8'h44);
        step(1);
        chk("R10 counting", {tens, units}, 8'h43);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        chk("R3 reset mid-run", {tens, units}, 8'h00);
        press(1);
        chk("R3 idle after reset", {tens, units}, 8'h11);
    endtask

    initial begin
        step(1);
        t_reset();
        t_decode();
        t_invalid();
        t_countdown();
        t_pause();
        t_start_zero();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule